// File: doc/BRIEF.md
# Bus-Master DMA Channel Command and Status Registers

This block holds the software-visible control state for one IDE channel of a PCI bus-master DMA engine. A command/status word at offset 0x00 carries the engine enable, the transfer direction, hardware status flags and a small scratch field for system software. A descriptor-table base address register sits at offset 0x04. Software reaches both words through a simple single-cycle register port with per-byte enables. Reads are combinational from the address.

Hardware reports its state on event inputs: transfer in progress, transfer complete, the device interrupt line, a bus fault, and the watchdog expiry of both channels. The block turns these into sticky or live status bits. It drives the engine enable and direction to the data mover. It produces a one-cycle abort pulse when software stops a running transfer, and it refuses task-file accesses while the engine is enabled.

Three reset inputs are honoured, all synchronous and active high: power-on (`rst_i`), bus reset (`pci_rst_i`) and a pulse marking entry into the deepest power state (`d3_enter_i`). The scratch field is split into three 2-bit slices. Each slice responds to a different set of these resets.

Top module: `dmareg_ctl`

## Requirements
- R1: At offset 0x00, bit 0 (enable) and bit 3 (direction, 1 = device to memory) are written through byte lane 0. Bits 7:4 and 2:1 always read zero.
- R2: `abort_o` pulses high for exactly one cycle, in the cycle after a write clears bit 0 while it was set and `dma_active_i` was high. A clear while `dma_active_i` is low gives no pulse.
- R3: `tf_abort_o` is high whenever `tf_access_i` is high while bit 0 is set, and low otherwise.
- R4: Bit 16 reads 1 only while `dma_active_i` is high and bit 0 is set.
- R5: Bit 17 sets in the cycle after `bus_err_i` is seen with bit 0 set. It clears on a lane-2 write with data bit 17 = 1. A fault arriving in the same cycle as that clear keeps the bit set.
- R6: With bit 0 clear, bit 18 shows the value `dev_irq_i` had one cycle earlier. With bit 0 set, it becomes sticky: it sets on `dev_irq_i` or `dma_done_i`, clears on a lane-2 write with data bit 18 = 1, and a new event wins over a simultaneous clear.
- R7: Bit 15 reads the OR of `wdog_own_i` and `wdog_peer_i`. Bit 14 reads `peer_irq_i`.
- R8: Scratch bits 13:8 are written through byte lane 1. Bits 11:10 clear on `rst_i` or `pci_rst_i`. Bits 9:8 clear only on `d3_enter_i`. Bits 13:12 are cleared by no reset.
- R9: At offset 0x04, bits 31:2 store the written data per byte lane, and bits 1:0 always read zero.
- R10: `rst_i` or `pci_rst_i` returns enable, direction, the status flags and the address register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Power-on reset, synchronous, active high |
| pci_rst_i | input | 1 | Bus reset, synchronous, active high |
| d3_enter_i | input | 1 | One-cycle pulse on entry to the deepest power state |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_be_i | input | 4 | Byte-lane write enables |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| dma_active_i | input | 1 | Data mover is transferring |
| dma_done_i | input | 1 | Data mover finished its descriptor list |
| dev_irq_i | input | 1 | Channel device interrupt line |
| bus_err_i | input | 1 | Bus fault while mastering |
| wdog_own_i | input | 1 | This channel's watchdog expired |
| wdog_peer_i | input | 1 | Other channel's watchdog expired |
| peer_irq_i | input | 1 | Other channel's completion interrupt bit |
| tf_access_i | input | 1 | A task-file or PIO data access is in progress |
| bm_en_o | output | 1 | Engine enable (bit 0) |
| bm_dir_o | output | 1 | Transfer direction (bit 3) |
| abort_o | output | 1 | One-cycle transfer abort pulse |
| tf_abort_o | output | 1 | Terminate the current task-file access with target-abort |

## Verification
The in-RTL assertions check the following on every cycle:
- the abort pulse lasts one cycle and always follows an enabled-to-disabled step;
- a bus fault is never lost to a simultaneous clear;
- the interrupt bit tracks the device line while the engine is idle;
- the retained scratch slices stay unchanged across a bus reset;
- the active bit and task-file refusal stay inside the enable.

Only the bench's scenarios can show the rest:
- the exact read-back values after byte-lane writes;
- the sticky interrupt clearing by write-1;
- the three different reset responses of the scratch slices, and the reset state of the whole word.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned LANES     = WORD_W / 8;

    // bit positions in the command/status word
    localparam int unsigned POS_EN    = 0;
    localparam int unsigned POS_DIR   = 3;
    localparam int unsigned POS_PEER  = 14;
    localparam int unsigned POS_WDOG  = 15;
    localparam int unsigned POS_ACT   = 16;
    localparam int unsigned POS_ERR   = 17;
    localparam int unsigned POS_IRQ   = 18;

    // scratch field
    localparam int unsigned SCR_LO    = 8;
    localparam int unsigned SCR_W     = 6;
    localparam int unsigned SCR_SLICE = 2;
    localparam int unsigned SCR_NSL   = SCR_W / SCR_SLICE;

    // descriptor base alignment
    localparam int unsigned BASE_ALIGN = 2;

    typedef enum logic [1:0] {
        CLR_NEVER = 2'd0,
        CLR_BUS   = 2'd1,
        CLR_DEEP  = 2'd2
    } clr_kind_e;

    typedef struct packed {
        logic active;
        logic done;
        logic dev_irq;
        logic bus_err;
        logic wdog_own;
        logic wdog_peer;
        logic peer_irq;
    } hw_evt_t;

    typedef struct packed {
        logic             en;
        logic             dir;
        logic             act;
        logic             err;
        logic             irq;
        logic             wdog;
        logic             peer_irq;
        logic [SCR_W-1:0] scratch;
    } cmd_view_t;

    // reset class of each scratch slice, lowest slice first
    function automatic clr_kind_e slice_kind(input int unsigned idx);
        case (idx)
            0:       return CLR_DEEP;
            1:       return CLR_BUS;
            default: return CLR_NEVER;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_cmd_word(input cmd_view_t v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_EN]                   = v.en;
        w[POS_DIR]                  = v.dir;
        w[SCR_LO +: SCR_W]          = v.scratch;
        w[POS_PEER]                 = v.peer_irq;
        w[POS_WDOG]                 = v.wdog;
        w[POS_ACT]                  = v.act;
        w[POS_ERR]                  = v.err;
        w[POS_IRQ]                  = v.irq;
        return w;
    endfunction

endpackage

// File: rtl/dmareg_cmd.sv
module dmareg_cmd
    import dmareg_pkg::*;
(
    input  logic clk_i,
    input  logic ctl_rst_i,
    input  logic we_i,
    input  logic en_wr_i,
    input  logic dir_wr_i,
    input  logic active_i,
    input  logic tf_access_i,
    output logic en_o,
    output logic dir_o,
    output logic abort_o,
    output logic tf_abort_o
);

    logic en_q, dir_q, abort_q;
    logic en_d;

    always_comb begin
        en_d = en_q;
        if (we_i) en_d = en_wr_i;
    end

    always_ff @(posedge clk_i) begin
        if (ctl_rst_i) begin
            en_q    <= 1'b0;
            dir_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            en_q    <= en_d;
            if (we_i) dir_q <= dir_wr_i;
            abort_q <= en_q & ~en_d & active_i;
        end
    end

    assign en_o       = en_q;
    assign dir_o      = dir_q;
    assign abort_o    = abort_q;
    assign tf_abort_o = tf_access_i & en_q;

    assert_abort_single_R2: assert property (@(posedge clk_i) disable iff (ctl_rst_i)
        abort_o |=> !abort_o);

    assert_abort_cause_R2: assert property (@(posedge clk_i) disable iff (ctl_rst_i)
        $rose(abort_o) |-> (!en_o && $past(en_o) && $past(active_i)));

endmodule

// File: rtl/dmareg_status.sv
module dmareg_status
    import dmareg_pkg::*;
(
    input  logic    clk_i,
    input  logic    ctl_rst_i,
    input  logic    en_i,
    input  hw_evt_t evt_i,
    input  logic    clr_err_i,
    input  logic    clr_irq_i,
    output logic    act_o,
    output logic    err_o,
    output logic    irq_o,
    output logic    wdog_o,
    output logic    peer_irq_o
);

    logic err_q, irq_q;
    logic err_set, irq_set;

    assign err_set = evt_i.bus_err & en_i;
    assign irq_set = evt_i.dev_irq | evt_i.done;

    always_ff @(posedge clk_i) begin
        if (ctl_rst_i) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            // hardware set wins over software clear
            if (err_set)        err_q <= 1'b1;
            else if (clr_err_i) err_q <= 1'b0;

            if (!en_i)          irq_q <= evt_i.dev_irq;
            else if (irq_set)   irq_q <= 1'b1;
            else if (clr_irq_i) irq_q <= 1'b0;
        end
    end

    assign act_o      = evt_i.active & en_i;
    assign err_o      = err_q;
    assign irq_o      = irq_q;
    assign wdog_o     = evt_i.wdog_own | evt_i.wdog_peer;
    assign peer_irq_o = evt_i.peer_irq;

    assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (ctl_rst_i)
        (evt_i.bus_err && en_i) |=> err_o);

    assert_irq_track_R6: assert property (@(posedge clk_i) disable iff (ctl_rst_i)
        !en_i |=> (irq_o == $past(evt_i.dev_irq)));

    assert_irq_event_R6: assert property (@(posedge clk_i) disable iff (ctl_rst_i)
        (en_i && (evt_i.dev_irq || evt_i.done)) |=> irq_o);

endmodule

// File: rtl/dmareg_scratch.sv
module dmareg_scratch
    import dmareg_pkg::*;
#(
    parameter int unsigned WIDTH = SCR_W,
    parameter int unsigned SLICE = SCR_SLICE
) (
    input  logic             clk_i,
    input  logic             por_rst_i,
    input  logic             bus_rst_i,
    input  logic             deep_i,
    input  logic             we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] scr_o
);

    localparam int unsigned NSL = WIDTH / SLICE;

    for (genvar s = 0; s < NSL; s++) begin : g_slice
        localparam clr_kind_e KIND = slice_kind(s);
        logic [SLICE-1:0] q;

        if (KIND == CLR_BUS) begin : g_bus
            always_ff @(posedge clk_i) begin
                if (por_rst_i || bus_rst_i) q <= '0;
                else if (we_i)              q <= wdata_i[s*SLICE +: SLICE];
            end
        end else if (KIND == CLR_DEEP) begin : g_deep
            always_ff @(posedge clk_i) begin
                if (deep_i)    q <= '0;
                else if (we_i) q <= wdata_i[s*SLICE +: SLICE];
            end
        end else begin : g_keep
            always_ff @(posedge clk_i) begin
                if (we_i) q <= wdata_i[s*SLICE +: SLICE];
            end
        end

        assign scr_o[s*SLICE +: SLICE] = q;
    end

    assert_keep_bus_R8: assert property (@(posedge clk_i)
        ((bus_rst_i || por_rst_i) && !we_i && !deep_i) |=> $stable(scr_o[SLICE-1:0]));

endmodule

// File: rtl/dmareg_base.sv
module dmareg_base
    import dmareg_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_W,
    parameter int unsigned ALIGN = BASE_ALIGN
) (
    input  logic                 clk_i,
    input  logic                 ctl_rst_i,
    input  logic                 we_i,
    input  logic [WIDTH/8-1:0]   be_i,
    input  logic [WIDTH-1:0]     wdata_i,
    output logic [WIDTH-1:0]     base_o
);

    localparam int unsigned NL = WIDTH / 8;

    logic [WIDTH-1:0] q;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        always_ff @(posedge clk_i) begin
            if (ctl_rst_i)            q[l*8 +: 8] <= '0;
            else if (we_i && be_i[l]) q[l*8 +: 8] <= wdata_i[l*8 +: 8];
        end
    end

    assign base_o = {q[WIDTH-1:ALIGN], {ALIGN{1'b0}}};

    assert_base_reset_R10: assert property (@(posedge clk_i)
        $past(ctl_rst_i) |-> (base_o == '0));

endmodule

// File: rtl/dmareg_ctl.sv
module dmareg_ctl
    import dmareg_pkg::*;
#(
    parameter int unsigned REG_AW  = 3,
    parameter int unsigned OFS_CMD = 0,
    parameter int unsigned OFS_PRD = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              pci_rst_i,
    input  logic              d3_enter_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [3:0]        reg_be_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              dma_active_i,
    input  logic              dma_done_i,
    input  logic              dev_irq_i,
    input  logic              bus_err_i,
    input  logic              wdog_own_i,
    input  logic              wdog_peer_i,
    input  logic              peer_irq_i,
    input  logic              tf_access_i,
    output logic              bm_en_o,
    output logic              bm_dir_o,
    output logic              abort_o,
    output logic              tf_abort_o
);

    localparam logic [REG_AW-1:0] A_CMD = REG_AW'(OFS_CMD);
    localparam logic [REG_AW-1:0] A_PRD = REG_AW'(OFS_PRD);

    logic ctl_rst;
    logic sel_cmd, sel_prd;
    logic we_cmd_l0, we_cmd_l1, we_cmd_l2, we_prd;
    logic clr_err, clr_irq;
    logic [WORD_W-1:0] base_w;
    logic [SCR_W-1:0]  scr_w;
    hw_evt_t   evt;
    cmd_view_t view;
    logic      unused_wd1;

    assign ctl_rst  = rst_i | pci_rst_i;
    assign sel_cmd  = (reg_addr_i == A_CMD);
    assign sel_prd  = (reg_addr_i == A_PRD);

    assign we_cmd_l0 = reg_wr_i & sel_cmd & reg_be_i[0];
    assign we_cmd_l1 = reg_wr_i & sel_cmd & reg_be_i[1];
    assign we_cmd_l2 = reg_wr_i & sel_cmd & reg_be_i[2];
    assign we_prd    = reg_wr_i & sel_prd;
    assign clr_err   = we_cmd_l2 & reg_wdata_i[POS_ERR];
    assign clr_irq   = we_cmd_l2 & reg_wdata_i[POS_IRQ];
    assign unused_wd1 = reg_wdata_i[1];

    assign evt = '{active:    dma_active_i,
                   done:      dma_done_i,
                   dev_irq:   dev_irq_i,
                   bus_err:   bus_err_i,
                   wdog_own:  wdog_own_i,
                   wdog_peer: wdog_peer_i,
                   peer_irq:  peer_irq_i};

    dmareg_cmd u_cmd (
        .clk_i       (clk_i),
        .ctl_rst_i   (ctl_rst),
        .we_i        (we_cmd_l0),
        .en_wr_i     (reg_wdata_i[POS_EN]),
        .dir_wr_i    (reg_wdata_i[POS_DIR]),
        .active_i    (dma_active_i),
        .tf_access_i (tf_access_i),
        .en_o        (view.en),
        .dir_o       (view.dir),
        .abort_o     (abort_o),
        .tf_abort_o  (tf_abort_o)
    );

    dmareg_status u_status (
        .clk_i      (clk_i),
        .ctl_rst_i  (ctl_rst),
        .en_i       (view.en),
        .evt_i      (evt),
        .clr_err_i  (clr_err),
        .clr_irq_i  (clr_irq),
        .act_o      (view.act),
        .err_o      (view.err),
        .irq_o      (view.irq),
        .wdog_o     (view.wdog),
        .peer_irq_o (view.peer_irq)
    );

    dmareg_scratch #(.WIDTH(SCR_W), .SLICE(SCR_SLICE)) u_scr (
        .clk_i     (clk_i),
        .por_rst_i (rst_i),
        .bus_rst_i (pci_rst_i),
        .deep_i    (d3_enter_i),
        .we_i      (we_cmd_l1),
        .wdata_i   (reg_wdata_i[SCR_LO +: SCR_W]),
        .scr_o     (scr_w)
    );

    assign view.scratch = scr_w;

    dmareg_base #(.WIDTH(WORD_W), .ALIGN(BASE_ALIGN)) u_base (
        .clk_i     (clk_i),
        .ctl_rst_i (ctl_rst),
        .we_i      (we_prd),
        .be_i      (reg_be_i),
        .wdata_i   (reg_wdata_i),
        .base_o    (base_w)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (sel_cmd)      reg_rdata_o = pack_cmd_word(view);
        else if (sel_prd) reg_rdata_o = base_w;
    end

    assign bm_en_o  = view.en;
    assign bm_dir_o = view.dir;

    assert_tf_refuse_R3: assert property (@(posedge clk_i) disable iff (ctl_rst)
        (tf_access_i && bm_en_o) |-> tf_abort_o);

    assert_tf_idle_R3: assert property (@(posedge clk_i) disable iff (ctl_rst)
        !bm_en_o |-> !tf_abort_o);

    assert_act_gate_R4: assert property (@(posedge clk_i) disable iff (ctl_rst)
        (sel_cmd && !bm_en_o) |-> !reg_rdata_o[POS_ACT]);

endmodule

// File: tb/dmareg_ctl_tb_top.sv
module dmareg_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_i, pci_rst_i, d3_enter_i;
    logic        reg_wr_i;
    logic [2:0]  reg_addr_i;
    logic [3:0]  reg_be_i;
    logic [31:0] reg_wdata_i, reg_rdata_o;
    logic        dma_active_i, dma_done_i, dev_irq_i, bus_err_i;
    logic        wdog_own_i, wdog_peer_i, peer_irq_i, tf_access_i;
    logic        bm_en_o, bm_dir_o, abort_o, tf_abort_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dmareg_ctl dut_i (
        .clk_i(clk), .rst_i(rst_i), .pci_rst_i(pci_rst_i), .d3_enter_i(d3_enter_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_be_i(reg_be_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .dma_active_i(dma_active_i), .dma_done_i(dma_done_i), .dev_irq_i(dev_irq_i),
        .bus_err_i(bus_err_i), .wdog_own_i(wdog_own_i), .wdog_peer_i(wdog_peer_i),
        .peer_irq_i(peer_irq_i), .tf_access_i(tf_access_i),
        .bm_en_o(bm_en_o), .bm_dir_o(bm_dir_o), .abort_o(abort_o), .tf_abort_o(tf_abort_o)
    );

    typedef struct packed {
        logic [2:0]  waddr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [2:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h0000_3F09, 4'b0011, 3'd0, 32'h0000_3F09},
        '{3'd0, 32'hFFFF_FFFF, 4'b0001, 3'd0, 32'h0000_3F09},
        '{3'd0, 32'h0000_0000, 4'b0010, 3'd0, 32'h0000_0009},
        '{3'd4, 32'hDEAD_BEEF, 4'b1111, 3'd4, 32'hDEAD_BEEC},
        '{3'd4, 32'h1234_5678, 4'b0100, 3'd4, 32'hDE34_BEEC},
        '{3'd0, 32'h0000_0000, 4'b0001, 3'd0, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // write: drive after a falling edge, the register takes it on the next rising edge
    task automatic reg_write(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; reg_be_i = be;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_be_i = '0;
    endtask

    function automatic logic [31:0] peek(input logic [2:0] a);
        reg_addr_i = a;
        return reg_rdata_o;
    endfunction

    task automatic read_chk(input string req, input logic [2:0] a, input logic [31:0] mask,
                            input logic [31:0] exp);
        reg_addr_i = a;
        #1;
        check(req, reg_rdata_o & mask, exp);
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic pulse_rst(input int which);
        @(negedge clk);
        if (which == 0) rst_i = 1'b1;
        else if (which == 1) pci_rst_i = 1'b1;
        else d3_enter_i = 1'b1;
        @(negedge clk);
        rst_i = 1'b0; pci_rst_i = 1'b0; d3_enter_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_i = 1'b1; pci_rst_i = 1'b1; d3_enter_i = 1'b0;
        reg_wr_i = 1'b0; reg_addr_i = '0; reg_be_i = '0; reg_wdata_i = '0;
        dma_active_i = 0; dma_done_i = 0; dev_irq_i = 0; bus_err_i = 0;
        wdog_own_i = 0; wdog_peer_i = 0; peer_irq_i = 0; tf_access_i = 0;
        repeat (3) @(negedge clk);
        rst_i = 1'b0; pci_rst_i = 1'b0;

        // R10 reset state (scratch bits 13:12 and 9:8 have no reset value)
        read_chk("R10 cmd reset", 3'd0, 32'hFFFF_CCFF, 32'h0);
        read_chk("R10 base reset", 3'd4, 32'hFFFF_FFFF, 32'h0);
        check("R10 enable out", {31'd0, bm_en_o}, 32'd0);

        // R1 R8 R9 vector walk
        for (int i = 0; i < NV; i++) begin
            reg_write(VECS[i].waddr, VECS[i].wdata, VECS[i].be);
            read_chk($sformatf("R1/R8/R9 vector %0d", i), VECS[i].raddr, 32'hFFFF_FFFF, VECS[i].exp);
        end
        reg_write(3'd0, 32'h8, 4'b0001);
        check("R1 direction out", {30'd0, bm_dir_o, bm_en_o}, 32'h2);

        // R4 active and R2 abort pulse
        reg_write(3'd0, 32'h1, 4'b0001);
        dma_active_i = 1'b1;
        read_chk("R4 active shown", 3'd0, 32'h0001_0000, 32'h0001_0000);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = 3'd0; reg_wdata_i = 32'h0; reg_be_i = 4'b0001;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_be_i = '0;
        check("R2 abort pulse", {31'd0, abort_o}, 32'd1);
        read_chk("R4 active hidden when disabled", 3'd0, 32'h0001_0000, 32'h0);
        tick();
        check("R2 abort one cycle", {31'd0, abort_o}, 32'd0);
        dma_active_i = 1'b0;
        reg_write(3'd0, 32'h1, 4'b0001);
        reg_write(3'd0, 32'h0, 4'b0001);
        check("R2 no abort when idle", {31'd0, abort_o}, 32'd0);

        // R3 task-file refusal
        tf_access_i = 1'b1; #1;
        check("R3 allowed when disabled", {31'd0, tf_abort_o}, 32'd0);
        reg_write(3'd0, 32'h1, 4'b0001);
        #1;
        check("R3 refused when enabled", {31'd0, tf_abort_o}, 32'd1);
        tf_access_i = 1'b0;

        // R5 bus error, set wins over clear
        bus_err_i = 1'b1; tick(); bus_err_i = 1'b0;
        read_chk("R5 error set", 3'd0, 32'h0002_0000, 32'h0002_0000);
        @(negedge clk);
        bus_err_i = 1'b1;
        reg_wr_i = 1'b1; reg_addr_i = 3'd0; reg_wdata_i = 32'h0002_0000; reg_be_i = 4'b0100;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_be_i = '0; bus_err_i = 1'b0;
        read_chk("R5 set beats clear", 3'd0, 32'h0002_0000, 32'h0002_0000);
        reg_write(3'd0, 32'h0002_0000, 4'b0100);
        read_chk("R5 error cleared", 3'd0, 32'h0002_0000, 32'h0);

        // R6 interrupt bit
        reg_write(3'd0, 32'h0, 4'b0001);
        dev_irq_i = 1'b1; tick();
        read_chk("R6 follows line high", 3'd0, 32'h0004_0000, 32'h0004_0000);
        dev_irq_i = 1'b0; tick();
        read_chk("R6 follows line low", 3'd0, 32'h0004_0000, 32'h0);
        reg_write(3'd0, 32'h1, 4'b0001);
        dev_irq_i = 1'b1; tick(); dev_irq_i = 1'b0; tick();
        read_chk("R6 sticky when enabled", 3'd0, 32'h0004_0000, 32'h0004_0000);
        reg_write(3'd0, 32'h0004_0000, 4'b0100);
        read_chk("R6 write-1 clear", 3'd0, 32'h0004_0000, 32'h0);
        dma_done_i = 1'b1; tick(); dma_done_i = 1'b0;
        read_chk("R6 set by completion", 3'd0, 32'h0004_0000, 32'h0004_0000);

        // R7 watchdog OR and peer copy
        wdog_own_i = 1'b1;
        read_chk("R7 own watchdog", 3'd0, 32'h0000_C000, 32'h0000_8000);
        wdog_own_i = 1'b0; wdog_peer_i = 1'b1;
        read_chk("R7 peer watchdog", 3'd0, 32'h0000_C000, 32'h0000_8000);
        wdog_peer_i = 1'b0; peer_irq_i = 1'b1;
        read_chk("R7 peer interrupt", 3'd0, 32'h0000_C000, 32'h0000_4000);
        peer_irq_i = 1'b0;

        // R8 scratch reset domains, R10 bus reset
        reg_write(3'd0, 32'h0000_3F00, 4'b0010);
        pulse_rst(1);
        read_chk("R8 bus reset slices", 3'd0, 32'h0000_3F00, 32'h0000_3300);
        read_chk("R10 bus reset clears control", 3'd0, 32'hFFFF_C0FF, 32'h0);
        read_chk("R10 bus reset clears base", 3'd4, 32'hFFFF_FFFF, 32'h0);
        reg_write(3'd0, 32'h0000_3F00, 4'b0010);
        pulse_rst(2);
        read_chk("R8 power-state slices", 3'd0, 32'h0000_3F00, 32'h0000_3C00);
        reg_write(3'd0, 32'h0000_3F00, 4'b0010);
        pulse_rst(0);
        read_chk("R8 power-on slices", 3'd0, 32'h0000_3F00, 32'h0000_3300);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule